// File: doc/BRIEF.md
# I2C Master Receive Engine

This block is the receive side of an I2C bus master. Software issues a receive command. The engine then produces eight SCL clock pulses, each half period timed by a reloadable baud counter, and shifts the SDA level into a shift register on every SCL rising edge. When the eighth pulse falls, the byte moves into a receive buffer. The engine then raises a buffer-full flag and an interrupt flag, stops the baud counter and keeps SCL pulled low, so the bus waits for the next command.

A separate acknowledge command produces a ninth SCL pulse. During that pulse the engine drives SDA with a bit chosen by software: a low bit acknowledges the byte, a high bit declines it. The interrupt flag is raised again when that pulse ends. Both bus lines are open drain. The block only ever pulls a line low or releases it. It also records two error conditions. The first is a byte that completes while the previous one has not been read. The second is a CPU write to the buffer while a byte is still being shifted in.

Top module: `i2cm_rx_engine`

## Requirements
- R1: `rcv_start` and `ack_start` are accepted only while `busy` is 0. At any other time they are ignored. If both are pulsed in the same idle cycle, the receive command wins.
- R2: Each SCL half period lasts `baud_reload`+1 clock cycles. After a receive command, SCL is pulled low (`scl_oe`=1) for the first half and then toggles on every counter rollover. `sda_in` is sampled, MSB first, at each low-to-high release. `sda_oe` stays 0 for the whole reception.
- R3: At the 16th rollover of a reception, `busy` falls and the sampled byte appears on `rx_data`. In the same cycle `buf_full` and `irq` go to 1 and `scl_oe` becomes 1. `scl_oe` stays at 1 until the next accepted command.
- R4: A `buf_rd` pulse clears `buf_full` on the next clock edge.
- R5: If a byte completes while `buf_full` is 1, `overflow` is set, the new byte is discarded, and `rx_data` keeps its old value.
- R6: A `buf_wr` pulse during a reception sets `wr_collision` and leaves `rx_data` unchanged. A `buf_wr` pulse at any other time loads `buf_wdata` into `rx_data` and does not change `buf_full`.
- R7: After an acknowledge command, `sda_oe` equals the inverse of `ack_nack` for two half periods: SCL low, then SCL released. SCL is then pulled low again. At that point `sda_oe` returns to 0 and `irq` is set.
- R8: `irq` clears only on `irq_clr`. `overflow` and `wr_collision` clear only on `err_clr`. If a set and a clear occur in the same cycle, the set wins.
- R9: After reset, `scl_oe`, `sda_oe`, `busy`, `buf_full`, `irq`, `overflow`, `wr_collision` and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_reload | input | BAUD_W | Half-period reload value (half period = value+1 cycles) |
| rcv_start | input | 1 | Receive-byte command pulse |
| ack_start | input | 1 | Acknowledge command pulse |
| ack_nack | input | 1 | Bit sent in the acknowledge slot: 0 acknowledges, 1 declines |
| buf_rd | input | 1 | CPU read strobe of the receive buffer |
| buf_wr | input | 1 | CPU write strobe of the buffer |
| buf_wdata | input | DATA_W | CPU write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| err_clr | input | 1 | Clears overflow and write-collision flags |
| sda_in | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A receive or acknowledge sequence is running |
| rx_data | output | DATA_W | Receive buffer contents |
| buf_full | output | 1 | Unread byte in the buffer |
| irq | output | 1 | Sticky interrupt flag |
| overflow | output | 1 | Sticky byte-lost flag |
| wr_collision | output | 1 | Sticky write-during-receive flag |

## Verification
Bytes are received with alternating bits (0xA5), a balanced nibble pattern (0x3C), all ones, end-bit-only (0x81) and a low-nibble pattern (0x0F). Between them these catch bit-order reversal, a missing or extra sample, and sampling on the wrong SCL edge. Several reload values are used, including 0, so any error in the half-period length or in the cycle of a rollover is visible in the cycle-by-cycle SCL comparison. The acknowledge sequence is run with both the acknowledge and the decline bit, which separates a correct drive from an always-driven or never-driven SDA. Stray commands and CPU writes injected during a reception show whether the engine ignores them or flags them as required.

// File: rtl/i2cm_rx_pkg.sv
package i2cm_rx_pkg;

    localparam int unsigned I2CM_DATA_W = 8;
    localparam int unsigned I2CM_BAUD_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RX   = 2'd1,
        ST_ACK  = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic buf_full;
        logic irq;
        logic overflow;
        logic wr_col;
    } rx_flags_t;

    // Open-drain pull request for the acknowledge slot: pull low to acknowledge.
    function automatic logic sda_pull_for(input logic nack);
        return ~nack;
    endfunction

endpackage

// File: rtl/i2cm_baud_tick.sv
module i2cm_baud_tick #(
    parameter int unsigned BAUD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              run,
    input  logic [BAUD_W-1:0] reload,
    output logic              tick
);
    logic [BAUD_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= reload;
        end else if (run) begin
            if (cnt == '0) cnt <= reload;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && (cnt == '0);

    // Counter is frozen when not running (R3: counter stops after the byte)
    assert_frozen_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/i2cm_rx_shifter.sv
module i2cm_rx_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              sample,
    input  logic              sda_in,
    output logic [DATA_W-1:0] shift_q
);
    always_ff @(posedge clk) begin
        if (rst)         shift_q <= '0;
        else if (clear)  shift_q <= '0;
        else if (sample) shift_q <= {shift_q[DATA_W-2:0], sda_in};
    end
endmodule

// File: rtl/i2cm_rx_status.sv
module i2cm_rx_status
    import i2cm_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_active,
    input  logic              load,
    input  logic [DATA_W-1:0] new_byte,
    input  logic              ack_done,
    input  logic              buf_rd,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              irq_clr,
    input  logic              err_clr,
    output logic [DATA_W-1:0] data_q,
    output rx_flags_t         fl_q
);
    logic wcol_hit, cpu_fill, keep_old, accept;

    assign wcol_hit = buf_wr && rx_active;
    assign cpu_fill = buf_wr && !rx_active;
    assign keep_old = load && fl_q.buf_full;
    assign accept   = load && !fl_q.buf_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            fl_q   <= '0;
        end else begin
            if (accept)        data_q <= new_byte;
            else if (cpu_fill) data_q <= wdata;

            fl_q.buf_full <= accept ? 1'b1 : (buf_rd ? 1'b0 : fl_q.buf_full);
            fl_q.irq      <= (load || ack_done) ? 1'b1 : (irq_clr ? 1'b0 : fl_q.irq);
            fl_q.overflow <= keep_old ? 1'b1 : (err_clr ? 1'b0 : fl_q.overflow);
            fl_q.wr_col   <= wcol_hit ? 1'b1 : (err_clr ? 1'b0 : fl_q.wr_col);
        end
    end

    assert_rd_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (buf_rd && !load) |=> !fl_q.buf_full);

    assert_overflow_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (load && fl_q.buf_full) |=> (fl_q.overflow && data_q == $past(data_q)));

    assert_wcol_keeps_R6: assert property (@(posedge clk) disable iff (rst)
        (buf_wr && rx_active && !load) |=> (fl_q.wr_col && data_q == $past(data_q)));

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (fl_q.irq && !irq_clr) |=> fl_q.irq);

endmodule

// File: rtl/i2cm_rx_engine.sv
module i2cm_rx_engine
    import i2cm_rx_pkg::*;
#(
    parameter int unsigned DATA_W = I2CM_DATA_W,
    parameter int unsigned BAUD_W = I2CM_BAUD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BAUD_W-1:0] baud_reload,
    input  logic              rcv_start,
    input  logic              ack_start,
    input  logic              ack_nack,
    input  logic              buf_rd,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              irq_clr,
    input  logic              err_clr,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              busy,
    output logic [DATA_W-1:0] rx_data,
    output logic              buf_full,
    output logic              irq,
    output logic              overflow,
    output logic              wr_collision
);
    localparam int HALF_W = $clog2(2 * DATA_W);
    localparam logic [HALF_W-1:0] RX_LAST  = HALF_W'(2 * DATA_W - 1);
    localparam logic [HALF_W-1:0] ACK_LAST = HALF_W'(1);

    eng_state_e        state;
    logic [HALF_W-1:0] hcnt;
    logic              scl_low, sda_drive;
    logic              tick, go_rx, go_ack, last_half, rx_done, ack_done, sample;
    logic [DATA_W-1:0] shift_q;
    rx_flags_t         flags;

    assign go_rx     = (state == ST_IDLE) && rcv_start;
    assign go_ack    = (state == ST_IDLE) && !rcv_start && ack_start;
    assign last_half = ((state == ST_RX)  && (hcnt == RX_LAST)) ||
                       ((state == ST_ACK) && (hcnt == ACK_LAST));
    assign rx_done   = tick && (state == ST_RX)  && (hcnt == RX_LAST);
    assign ack_done  = tick && (state == ST_ACK) && (hcnt == ACK_LAST);
    assign sample    = tick && (state == ST_RX)  && !hcnt[0];

    i2cm_baud_tick #(.BAUD_W(BAUD_W)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .load   (go_rx || go_ack),
        .run    (state != ST_IDLE),
        .reload (baud_reload),
        .tick   (tick)
    );

    i2cm_rx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .clear   (go_rx),
        .sample  (sample),
        .sda_in  (sda_in),
        .shift_q (shift_q)
    );

    i2cm_rx_status #(.DATA_W(DATA_W)) u_status (
        .clk       (clk),
        .rst       (rst),
        .rx_active (state == ST_RX),
        .load      (rx_done),
        .new_byte  (shift_q),
        .ack_done  (ack_done),
        .buf_rd    (buf_rd),
        .buf_wr    (buf_wr),
        .wdata     (buf_wdata),
        .irq_clr   (irq_clr),
        .err_clr   (err_clr),
        .data_q    (rx_data),
        .fl_q      (flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            hcnt      <= '0;
            scl_low   <= 1'b0;
            sda_drive <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (go_rx) begin
                        state   <= ST_RX;
                        hcnt    <= '0;
                        scl_low <= 1'b1;
                    end else if (go_ack) begin
                        state     <= ST_ACK;
                        hcnt      <= '0;
                        scl_low   <= 1'b1;
                        sda_drive <= sda_pull_for(ack_nack);
                    end
                end
                default: begin
                    if (tick) begin
                        if (last_half) begin
                            state     <= ST_IDLE;
                            scl_low   <= 1'b1;
                            sda_drive <= 1'b0;
                        end else begin
                            hcnt    <= hcnt + 1'b1;
                            scl_low <= hcnt[0];
                        end
                    end
                end
            endcase
        end
    end

    assign scl_oe       = scl_low;
    assign sda_oe       = sda_drive;
    assign busy         = (state != ST_IDLE);
    assign buf_full     = flags.buf_full;
    assign irq          = flags.irq;
    assign overflow     = flags.overflow;
    assign wr_collision = flags.wr_col;

    assert_scl_held_after_seq_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> scl_oe);

    assert_sda_free_in_rx_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RX) |-> !sda_oe);

    assert_start_ignored_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RX && !tick) |=> (state == ST_RX));

    assert_ack_release_R7: assert property (@(posedge clk) disable iff (rst)
        ack_done |=> (!sda_oe && irq));

endmodule

// File: tb/test_i2cm_rx_engine.sv
`timescale 1ns/1ps
module test_i2cm_rx_engine;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] baud_reload = 8'd3;
    logic       rcv_start = 0, ack_start = 0, ack_nack = 0;
    logic       buf_rd = 0, buf_wr = 0, irq_clr = 0, err_clr = 0;
    logic [7:0] buf_wdata = 8'd0;
    logic       slave_bit = 1'b1;
    logic       sda_in;
    logic       scl_oe, sda_oe, busy, buf_full, irq, overflow, wr_collision;
    logic [7:0] rx_data;
    logic [7:0] tx_byte = 8'd0;

    always #2.5 clk = ~clk;

    assign sda_in = sda_oe ? 1'b0 : slave_bit;

    i2cm_rx_engine i_i2cm_rx_engine (
        .clk(clk), .rst(rst), .baud_reload(baud_reload),
        .rcv_start(rcv_start), .ack_start(ack_start), .ack_nack(ack_nack),
        .buf_rd(buf_rd), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
        .irq_clr(irq_clr), .err_clr(err_clr), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .rx_data(rx_data),
        .buf_full(buf_full), .irq(irq), .overflow(overflow),
        .wr_collision(wr_collision)
    );

    int n_vec = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: time since command, counted in cycles.
    int m_mode = 0, m_t = 0, m_p = 1, m_byte = 0, m_data = 0;
    int m_full = 0, m_irq = 0, m_ovf = 0, m_wcol = 0, m_held = 0, m_drv = 0;

    always @(posedge clk) begin : ref_model
        int k, old_mode, old_full;
        bit fin_rx, fin_ack;
        if (rst) begin
            m_mode = 0; m_t = 0; m_byte = 0; m_data = 0; m_full = 0;
            m_irq = 0; m_ovf = 0; m_wcol = 0; m_held = 0; m_drv = 0;
        end else begin
            old_mode = m_mode; old_full = m_full;
            fin_rx = 0; fin_ack = 0;
            if (m_mode != 0) begin
                m_t++;
                if (m_t % m_p == 0) begin
                    k = m_t / m_p;
                    if (m_mode == 1 && (k % 2) == 1) m_byte = ((m_byte << 1) | int'(sda_in)) & 255;
                    if (m_mode == 1 && k == 16) fin_rx = 1;
                    if (m_mode == 2 && k == 2)  fin_ack = 1;
                end
            end
            if (err_clr) begin m_ovf = 0; m_wcol = 0; end
            if (irq_clr) m_irq = 0;
            if (buf_wr) begin
                if (old_mode == 1) m_wcol = 1;
                else m_data = int'(buf_wdata);
            end
            if (buf_rd) m_full = 0;
            if (fin_rx) begin
                if (old_full != 0) m_ovf = 1;
                else begin m_data = m_byte; m_full = 1; end
            end
            if (fin_rx || fin_ack) begin
                m_irq = 1; m_mode = 0; m_drv = 0;
            end else if (old_mode == 0 && rcv_start) begin
                m_mode = 1; m_t = 0; m_byte = 0; m_held = 1; m_p = int'(baud_reload) + 1;
            end else if (old_mode == 0 && ack_start) begin
                m_mode = 2; m_t = 0; m_held = 1; m_drv = ack_nack ? 0 : 1;
                m_p = int'(baud_reload) + 1;
            end
        end
    end

    // Slave drive and per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (m_mode == 1) begin
            int idx;
            idx = (m_t / m_p) / 2;
            if (idx < 8) slave_bit = tx_byte[7 - idx];
        end else begin
            slave_bit = 1'b1;
        end
        if (!rst) begin
            chk("R2 R3 scl_oe", int'(scl_oe), (m_mode == 0) ? m_held : (((m_t / m_p) % 2 == 0) ? 1 : 0));
            chk("R2 R7 sda_oe", int'(sda_oe), (m_mode == 2) ? m_drv : 0);
            chk("R1 busy", int'(busy), (m_mode != 0) ? 1 : 0);
            chk("R3 R5 R6 rx_data", int'(rx_data), m_data);
            chk("R3 R4 buf_full", int'(buf_full), m_full);
            chk("R3 R7 R8 irq", int'(irq), m_irq);
            chk("R5 R8 overflow", int'(overflow), m_ovf);
            chk("R6 R8 wr_collision", int'(wr_collision), m_wcol);
        end
    end

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic run_rx(input logic [7:0] b, input logic [7:0] r);
        @(negedge clk); tx_byte = b; baud_reload = r; rcv_start = 1;
        @(negedge clk); rcv_start = 0;
        wait_idle();
    endtask

    task automatic run_ack(input logic nack, input logic [7:0] r);
        @(negedge clk); ack_nack = nack; baud_reload = r; ack_start = 1;
        @(negedge clk); ack_start = 0;
        wait_idle();
    endtask

    task automatic strobe_rd();  @(negedge clk); buf_rd = 1;  @(negedge clk); buf_rd = 0;  endtask
    task automatic strobe_irq(); @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0; endtask
    task automatic strobe_err(); @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0; endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1 R3 actual=running expected=finished");
        finish_run();
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        // R9: reset values
        chk("R9 scl_oe", int'(scl_oe), 0);
        chk("R9 sda_oe", int'(sda_oe), 0);
        chk("R9 busy", int'(busy), 0);
        chk("R9 flags", int'({buf_full, irq, overflow, wr_collision}), 0);
        chk("R9 rx_data", int'(rx_data), 0);
        rst = 0;

        // R2 R3: alternating pattern, reload 3
        run_rx(8'hA5, 8'd3);
        chk("R3 byte 0xA5", int'(rx_data), 165);
        chk("R3 buf_full", int'(buf_full), 1);
        chk("R3 scl held", int'(scl_oe), 1);
        repeat (5) @(negedge clk);
        chk("R3 scl still held", int'(scl_oe), 1);
        strobe_rd();
        chk("R4 buf_full cleared", int'(buf_full), 0);
        chk("R8 irq kept before clear", int'(irq), 1);
        strobe_irq();
        chk("R8 irq cleared", int'(irq), 0);

        // R7: acknowledge with ACK then NACK
        run_ack(1'b0, 8'd2);
        chk("R7 irq after ack", int'(irq), 1);
        chk("R7 sda released", int'(sda_oe), 0);
        strobe_irq();
        run_ack(1'b1, 8'd1);
        chk("R7 irq after nack", int'(irq), 1);
        strobe_irq();

        // R5: overflow keeps old byte
        run_rx(8'h3C, 8'd1);
        chk("R3 byte 0x3C", int'(rx_data), 60);
        run_rx(8'hFF, 8'd1);
        chk("R5 overflow set", int'(overflow), 1);
        chk("R5 old byte kept", int'(rx_data), 60);
        chk("R5 buf_full stays", int'(buf_full), 1);
        strobe_rd();
        strobe_err();
        chk("R8 overflow cleared", int'(overflow), 0);

        // R6 R1: write and stray commands during reception, reload 0
        @(negedge clk); tx_byte = 8'h81; baud_reload = 8'd0; rcv_start = 1;
        @(negedge clk); rcv_start = 0;
        @(negedge clk); buf_wr = 1; buf_wdata = 8'h55;
        @(negedge clk); buf_wr = 0; rcv_start = 1;
        @(negedge clk); rcv_start = 0; ack_start = 1;
        @(negedge clk); ack_start = 0;
        wait_idle();
        chk("R6 collision flagged", int'(wr_collision), 1);
        chk("R6 R1 byte 0x81", int'(rx_data), 129);
        @(negedge clk); buf_wr = 1; buf_wdata = 8'h5A;
        @(negedge clk); buf_wr = 0;
        chk("R6 idle write loads", int'(rx_data), 90);
        chk("R6 buf_full untouched", int'(buf_full), 1);
        strobe_rd();
        strobe_err();
        strobe_irq();

        // R1: both commands in one idle cycle -> receive
        @(negedge clk); tx_byte = 8'h0F; baud_reload = 8'd2; rcv_start = 1; ack_start = 1;
        @(negedge clk); rcv_start = 0; ack_start = 0;
        chk("R1 receive wins sda", int'(sda_oe), 0);
        wait_idle();
        chk("R1 byte 0x0F", int'(rx_data), 15);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule